// File: doc/BRIEF.md
# Mode-Configurable SECDED Protected RAM

A synchronous, single-clock memory that stores 32-bit data words together with 7 check bits. An extended Hamming code guards each stored word. It corrects any single flipped bit on the way out and flags any two flipped bits. Two elaboration-time parameters pick the mode:
- **Combined mode:** the encoder fills in the check bits on every write, and the decoder corrects every read.
- **Encode-only mode:** the decoder is removed, so reads return the stored data and check bits exactly as held.
- **Decode-only mode:** the encoder is bypassed, so the caller writes the whole 39-bit word (data plus both check fields) directly, and reads are still corrected.

With both parameters off, elaboration stops with a fatal error.

The check word `chk[6:0]` is split over two fields: `chk[3:0]` travels on the low check field and `chk[6:4]` on the high check field. Reads take one cycle. Data, check fields, the read-valid strobe and the two error flags all appear in the cycle after the read request. The decoder never writes a fix back, so a damaged word stays damaged in the array.

Top module: `secded_ram`

## Requirements
- R1: With the encoder on, a write stores check bits computed from the write data, with all parity taken as XOR:
  - Data bit i sits at the i-th position in 1..38 that is not a power of two, so bit 0 is at position 3.
  - `chk[5:0]` is the XOR of the positions of all set data bits.
  - `chk[6]` is the parity of the 32 data bits and `chk[5:0]`.
  - A later read returns the data unchanged, with `rdChkLo = chk[3:0]` and `rdChkHi = chk[6:4]`.
- R2: `rdValid` is high in exactly the cycle after each cycle with `rdEn` high. Read data and check fields for that request are presented in that same cycle.
- R3: With the decoder on, a stored word with one flipped data bit reads back with corrected data, `sbitErr` = 1 and `dbitErr` = 0.
- R4: With the decoder on, a stored word with one flipped check bit reads back with unchanged data and `sbitErr` = 1.
- R5: With the decoder on, a stored word with two flipped bits reads back with the uncorrected stored data, `dbitErr` = 1 and `sbitErr` = 0.
- R6: A detected error is not written back. Reading the same address again gives the same flag and the same stored check fields.
- R7: With the decoder off, reads return the stored data and check bits unmodified, and both error flags stay 0.
- R8: With the encoder off, the write word `{wrChkHi, wrChkLo, wrData}` is stored exactly as given. A clean word reads back with both flags 0.
- R9: Both error flags are 0 in any cycle where `rdValid` is 0, and after any read of a clean word.
- R10: While reset is held, `rdValid`, `sbitErr` and `dbitErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| wrEn | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| wrChkLo | input | 4 | Raw check bits 3..0 (used with the encoder off) |
| wrChkHi | input | 3 | Raw check bits 6..4 (used with the encoder off) |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdValid | output | 1 | Read result valid, one cycle after `rdEn` |
| rdData | output | 32 | Read data, corrected when the decoder is on |
| rdChkLo | output | 4 | Stored check bits 3..0 |
| rdChkHi | output | 3 | Stored check bits 6..4 |
| sbitErr | output | 1 | Single-bit error detected and corrected |
| dbitErr | output | 1 | Double-bit error detected, data uncorrected |

## Verification
The assertions on flag exclusivity and data pass-through assume that no stored word has more than two flipped bits. Beyond two flips, the code may classify a word wrongly. The bench therefore injects only zero, one or two flips, through the raw write path of the decode-only instance. It sweeps every single position and every pair of positions in the 39-bit word. The stimulus also never reads and writes the same address in one cycle, so no read-during-write ordering is assumed.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;
  localparam int DataW = 32;
  localparam int HamW  = 6;
  localparam int ChkW  = HamW + 1;
  localparam int LoW   = 4;
  localparam int HiW   = ChkW - LoW;
  localparam int WordW = DataW + ChkW;

  typedef logic [DataW-1:0] data_t;
  typedef logic [ChkW-1:0]  chk_t;

  typedef struct packed {
    logic memWrite;
    logic memRead;
    logic rdValid;
  } ctrl_strobe_t;

  // Code position of data bit idx: the idx-th non-power-of-two above 2.
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits covered by Hamming check bit k.
  function automatic data_t checkMask(input int k);
    data_t m;
    for (int i = 0; i < DataW; i++) begin
      int p;
      p = dataPos(i);
      m[i] = p[k];
    end
    return m;
  endfunction

  function automatic chk_t secdedEncode(input data_t d);
    chk_t c;
    for (int k = 0; k < HamW; k++) c[k] = ^(d & checkMask(k));
    c[ChkW-1] = (^d) ^ (^c[HamW-1:0]);
    return c;
  endfunction

  function automatic void secdedDecode(input data_t d, input chk_t c,
                                       output data_t fixed, output logic sErr,
                                       output logic dErr);
    logic [HamW-1:0] syn;
    logic ovBad;
    for (int k = 0; k < HamW; k++) syn[k] = c[k] ^ (^(d & checkMask(k)));
    ovBad = (^d) ^ (^c);
    fixed = d;
    for (int i = 0; i < DataW; i++) begin
      if (ovBad && (int'(syn) == dataPos(i))) fixed[i] = ~d[i];
    end
    sErr = ovBad;
    dErr = !ovBad && (syn != '0);
  endfunction
endpackage

// File: rtl/secded_ctrl.sv
`timescale 1ns/1ps
module secded_ctrl
  import secded_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  output ctrl_strobe_t stb
);
  logic rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= rdEn;
  end

  always_comb begin
    stb.memWrite = wrEn;
    stb.memRead  = rdEn;
    stb.rdValid  = rdValidQ;
  end

  // R2: valid follows a read by one cycle, and only then
  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> stb.rdValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !stb.rdValid);
endmodule

// File: rtl/secded_datapath.sv
`timescale 1ns/1ps
module secded_datapath
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  data_t             wrData,
  input  logic [LoW-1:0]    wrChkLo,
  input  logic [HiW-1:0]    wrChkHi,
  input  logic [ADDR_W-1:0] rdAddr,
  output data_t             rdData,
  output logic [LoW-1:0]    rdChkLo,
  output logic [HiW-1:0]    rdChkHi,
  output logic              sbitErr,
  output logic              dbitErr
);
  localparam int Depth = 1 << ADDR_W;

  logic [WordW-1:0] mem [Depth];
  chk_t  wrChk;
  data_t rawDataQ;
  chk_t  rawChkQ;
  data_t fixedData;
  logic  sHit, dHit;

  generate
    if (!ENC_EN && !DEC_EN) begin : g_bad_mode
      $fatal(1, "secded_datapath: encoder and decoder both disabled");
    end
  endgenerate

  always_comb wrChk = ENC_EN ? secdedEncode(wrData) : {wrChkHi, wrChkLo};

  always_ff @(posedge clk) begin
    if (stb.memWrite) mem[wrAddr] <= {wrChk, wrData};
    if (stb.memRead)  {rawChkQ, rawDataQ} <= mem[rdAddr];
  end

  always_comb secdedDecode(rawDataQ, rawChkQ, fixedData, sHit, dHit);

  always_comb begin
    rdData  = DEC_EN ? fixedData : rawDataQ;
    rdChkLo = rawChkQ[LoW-1:0];
    rdChkHi = rawChkQ[ChkW-1:LoW];
    sbitErr = DEC_EN && stb.rdValid && sHit;
    dbitErr = DEC_EN && stb.rdValid && dHit;
  end

  // R9: flags only beside a valid read
  a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (sbitErr || dbitErr) |-> stb.rdValid);
  // R5: single and double never reported together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sbitErr && dbitErr));
  // R5: a double error leaves the data as stored
  a_r5_double_keeps_raw: assert property (@(posedge clk) disable iff (!rstN)
    dbitErr |-> (rdData == rawDataQ));
  // R3: a clean valid read passes data through untouched
  a_r3_clean_passes: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdValid && !sbitErr && !dbitErr) |-> (rdData == rawDataQ));

  generate
    if (!DEC_EN) begin : g_nodec_chk
      // R7: no flags without a decoder
      a_r7_no_flags: assert property (@(posedge clk) disable iff (!rstN)
        !sbitErr && !dbitErr);
    end
  endgenerate
endmodule

// File: rtl/secded_ram.sv
`timescale 1ns/1ps
module secded_ram
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrChkLo,
  input  logic [2:0]        wrChkHi,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic [3:0]        rdChkLo,
  output logic [2:0]        rdChkHi,
  output logic              sbitErr,
  output logic              dbitErr
);
  ctrl_strobe_t stb;

  secded_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  secded_datapath #(.ADDR_W(ADDR_W), .ENC_EN(ENC_EN), .DEC_EN(DEC_EN)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .wrChkLo(wrChkLo), .wrChkHi(wrChkHi),
    .rdAddr(rdAddr), .rdData(rdData), .rdChkLo(rdChkLo), .rdChkHi(rdChkHi),
    .sbitErr(sbitErr), .dbitErr(dbitErr)
  );

  assign rdValid = stb.rdValid;
endmodule

// File: tb/secded_ram_tb_top.sv
`timescale 1ns/1ps
module secded_ram_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic          wrEn = 0, rdEn = 0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0]   wrData = '0;
  logic [3:0]    wrChkLo = '0;
  logic [2:0]    wrChkHi = '0;

  logic [31:0] dF, dE, dD;
  logic [3:0]  lF, lE, lD;
  logic [2:0]  hF, hE, hD;
  logic vF, vE, vD, sF, sE, sD, bF, bE, bD;

  secded_ram #(.ADDR_W(AW), .ENC_EN(1'b1), .DEC_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrChkLo(wrChkLo), .wrChkHi(wrChkHi), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdValid(vF), .rdData(dF), .rdChkLo(lF), .rdChkHi(hF), .sbitErr(sF), .dbitErr(bF));
  secded_ram #(.ADDR_W(AW), .ENC_EN(1'b1), .DEC_EN(1'b0)) dutEnc_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrChkLo(wrChkLo), .wrChkHi(wrChkHi), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdValid(vE), .rdData(dE), .rdChkLo(lE), .rdChkHi(hE), .sbitErr(sE), .dbitErr(bE));
  secded_ram #(.ADDR_W(AW), .ENC_EN(1'b0), .DEC_EN(1'b1)) dutDec_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrChkLo(wrChkLo), .wrChkHi(wrChkHi), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdValid(vD), .rdData(dD), .rdChkLo(lD), .rdChkHi(hD), .sbitErr(sD), .dbitErr(bD));

  // Check word: low 6 bits are the XOR of code positions of set data bits.
  function automatic logic [6:0] modelChk(input logic [31:0] d);
    logic [5:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h = h ^ 6'(p);
        k++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleFlags(input string req);
    check({req, " valid low"}, {61'd0, vF, vE, vD}, 64'd0);
    check({req, " flags low"}, {58'd0, sF, bF, sE, bE, sD, bD}, 64'd0);
  endtask

  int caseNo = 0;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic runCase(input logic [38:0] errMask, input int nErr, input bit again);
    logic [31:0] d;
    logic [38:0] word;
    logic [AW-1:0] a;
    logic [31:0] expD;
    string tag;
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    d = lcg ^ (32'h1 << (caseNo % 32));
    word = {modelChk(d), d} ^ errMask;
    a = AW'(caseNo);
    caseNo++;
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = word[31:0];
    wrChkLo = word[35:32]; wrChkHi = word[38:36];
    @(negedge clk);
    wrEn = 0; rdEn = 1; rdAddr = a;
    @(negedge clk);
    rdEn = 0;
    check("R2 valid after read", {61'd0, vF, vE, vD}, 64'h7);
    check("R1 combined data", 64'(dF), 64'(word[31:0]));
    check("R1 combined check", 64'({hF, lF}), 64'(modelChk(word[31:0])));
    check("R9 combined clean flags", {62'd0, sF, bF}, 64'd0);
    check("R1 encode-only data", 64'(dE), 64'(word[31:0]));
    check("R7 encode-only check raw", 64'({hE, lE}), 64'(modelChk(word[31:0])));
    check("R7 encode-only flags low", {62'd0, sE, bE}, 64'd0);
    check("R8 decode-only stored check", 64'({hD, lD}), 64'(word[38:32]));
    expD = (nErr <= 1) ? d : word[31:0];
    if (nErr == 0) tag = "R8 clean";
    else if (nErr == 2) tag = "R5 double";
    else if (errMask[31:0] != 0) tag = "R3 data single";
    else tag = "R4 check single";
    check({tag, " data"}, 64'(dD), 64'(expD));
    check({tag, " flags"}, {62'd0, sD, bD}, {62'd0, nErr == 1, nErr == 2});
    if (again) begin
      rdEn = 1;
      @(negedge clk);
      rdEn = 0;
      check("R6 reread flags", {62'd0, sD, bD}, {62'd0, nErr == 1, nErr == 2});
      check("R6 reread check", 64'({hD, lD}), 64'(word[38:32]));
      check("R6 reread data", 64'(dD), 64'(expD));
    end
    @(negedge clk);
    idleFlags("R2/R9 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idleFlags("R10 reset");
    rstN = 1;
    // clean words in every address
    for (int i = 0; i < 20; i++) runCase(39'd0, 0, 1'b0);
    // every single flip, reread to confirm no write-back
    for (int b = 0; b < 39; b++) runCase(39'd1 << b, 1, 1'b1);
    // every pair of flips
    for (int a = 0; a < 39; a++)
      for (int b = a + 1; b < 39; b++)
        runCase((39'd1 << a) | (39'd1 << b), 2, a == 0);
    // clean read after an error clears flags
    runCase(39'd1 << 5, 1, 1'b0);
    runCase(39'd0, 0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule